// File: doc/BRIEF.md
# Two-Level Peripheral Interrupt Aggregator

The aggregator gathers edge-triggered interrupt lines from a large population of peripheral IDs, each carrying eight lines. Every rising edge on a line sets a sticky status bit. Software clears status bits by writing ones, and gates each ID's effect on the summaries with an enable bit. Each ID is tagged with an owner number. For every owner the block forms 32-bit summary words, one bit per ID. A single interrupt output is raised whenever any summary bit of the currently selected owner is set.

A hardware scanner walks the summary words of the selected owner, restricted to the words that span the lowest and highest registered IDs. It offers the next pending (ID, line) pair on a valid/ready handshake, lowest ID first and lowest line first within that ID. Accepting the pair clears exactly that line, in the same way as a one-hot clear write. IDs are registered by writing them to the bounds register, which only widens the scanned range.

The register port uses a 12-bit address. Bits [11:9] select a region and bits [8:0] select an ID. The region codes are: 0 enable, 1 owner, 2 status, 3 clear, 4 summary, 5 bounds.

Top module: `irq_aggregator`

## Requirements
- R1: A status bit sets on the first cycle its raw line is sampled high after being sampled low. A line held high does not set the bit again after it has been cleared.
- R2: A write to region 3 clears the status bits of that ID where wdata[7:0] is one. A rising edge on the same line in the same cycle wins, and the bit stays set.
- R3: Region 4 reads the summary word whose owner is index bits [6:4] and whose word number is index bits [3:0]. Bit k of word n is one exactly when ID n*32+k is enabled, has nonzero status and has that owner.
- R4: The enable bit (region 0, bit 0, reset 0) gates only the summaries. Status bits latch whether or not the ID is enabled.
- R5: irq_out is the OR of all summary bits of owner cfg_owner. It follows a status, enable or owner change one cycle later.
- R6: An ID contributes only to its own owner's summaries. Owner values 6 and 7, and a cfg_owner of 6 or 7, produce no summary bits and no interrupt.
- R7: After reset the bounds read (region 5) gives min=511 in bits [8:0] and max=0 in bits [24:16]. Writing an ID in wdata[8:0] lowers min and raises max to include it.
- R8: The scanner offers the pending pair with the lowest ID, and within that ID the lowest pending line, among enabled IDs of owner cfg_owner.
- R9: Only IDs whose summary word lies between min>>5 and max>>5 inclusive are offered. These include IDs in those words that fall outside [min, max]. Nothing is offered while no ID is registered.
- R10: A handshake (nxt_valid and nxt_ready both high) clears only the offered line of the offered ID. It drops nxt_valid in the next cycle, and scanning then restarts from the first word.
- R11: While nxt_valid is high and nxt_ready is low, nxt_valid, nxt_id and nxt_line stay unchanged.
- R12: Reads return data in reg_rdata in the cycle after reg_rd, and the value holds until the next read. Region 0 returns the enable in bit 0, region 1 the owner in bits [2:0], region 2 the status in bits [7:0], and region 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_raw | input | 4096 | Raw lines, line l of ID i at bit i*8+l |
| cfg_owner | input | 3 | Owner whose summaries drive irq_out and the scanner |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Region [11:9], ID or summary index [8:0] |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Aggregate interrupt for cfg_owner |
| nxt_valid | output | 1 | A pending pair is offered |
| nxt_id | output | 9 | Offered ID |
| nxt_line | output | 3 | Offered line |
| nxt_ready | input | 1 | Accept the offered pair |

## Verification
A raw edge or clear write takes effect at the clock edge that samples it, so status reads are due one edge after the stimulus and read data one edge after reg_rd. irq_out trails a status, enable or owner change by one further edge, so the bench waits an extra falling edge before sampling it. The scanner needs one edge to pick a word and one more to present the pair, plus one edge per empty word it walks. For that reason the bench polls nxt_valid for a bounded number of cycles rather than at a fixed edge. All inputs change and all outputs are sampled on the falling edge.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  typedef enum logic [2:0] {
    RG_ENABLE  = 3'd0,
    RG_OWNER   = 3'd1,
    RG_STATUS  = 3'd2,
    RG_CLEAR   = 3'd3,
    RG_SUMMARY = 3'd4,
    RG_BOUNDS  = 3'd5
  } region_e;

  typedef enum logic [1:0] {
    SC_SCAN = 2'd0,
    SC_LINE = 2'd1,
    SC_HOLD = 2'd2
  } scan_state_e;

endpackage

// File: rtl/irqagg_id_bank.sv
module irqagg_id_bank #(
  parameter int NUM_IDS = 512,
  parameter int LINES   = 8,
  parameter int OWN_W   = 3,
  localparam int IDX_W  = $clog2(NUM_IDS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_IDS*LINES-1:0]   raw,
  input  logic                       cfg_we,
  input  logic                       cfg_sel_owner,
  input  logic [IDX_W-1:0]           cfg_idx,
  input  logic [OWN_W-1:0]           cfg_data,
  input  logic                       clr_a_en,
  input  logic [IDX_W-1:0]           clr_a_idx,
  input  logic [LINES-1:0]           clr_a_mask,
  input  logic                       clr_b_en,
  input  logic [IDX_W-1:0]           clr_b_idx,
  input  logic [LINES-1:0]           clr_b_mask,
  output logic [NUM_IDS*LINES-1:0]   status_flat,
  output logic [NUM_IDS-1:0]         enable_vec,
  output logic [NUM_IDS*OWN_W-1:0]   owner_flat
);

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_id
    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] st_q;
    logic [LINES-1:0] rise;
    logic [LINES-1:0] clr;
    logic             en_q;
    logic [OWN_W-1:0] own_q;
    logic             hit_a;
    logic             hit_b;

    assign hit_a = clr_a_en && (clr_a_idx == IDX_W'(g));
    assign hit_b = clr_b_en && (clr_b_idx == IDX_W'(g));
    assign rise  = raw[g*LINES +: LINES] & ~prev_q;
    assign clr   = (hit_a ? clr_a_mask : '0) | (hit_b ? clr_b_mask : '0);

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q <= '0;
        st_q   <= '0;
        en_q   <= 1'b0;
        own_q  <= '0;
      end else begin
        prev_q <= raw[g*LINES +: LINES];
        st_q   <= (st_q & ~clr) | rise;
        if (cfg_we && (cfg_idx == IDX_W'(g))) begin
          if (cfg_sel_owner) own_q <= cfg_data;
          else               en_q  <= cfg_data[0];
        end
      end
    end

    assign status_flat[g*LINES +: LINES] = st_q;
    assign enable_vec[g]                 = en_q;
    assign owner_flat[g*OWN_W +: OWN_W]  = own_q;

    // R1
    rise_latch_chk: assert property (@(posedge clk) disable iff (rst)
      (|rise) |=> ((st_q & $past(rise)) == $past(rise)));

    // R2
    clr_apply_chk: assert property (@(posedge clk) disable iff (rst)
      (|(clr & ~rise)) |=> ((st_q & $past(clr & ~rise)) == '0));
  end

endmodule

// File: rtl/irqagg_summary.sv
module irqagg_summary #(
  parameter int NUM_IDS    = 512,
  parameter int LINES      = 8,
  parameter int OWN_W      = 3,
  parameter int NUM_OWNERS = 6,
  parameter int SUM_W      = 32,
  localparam int NUM_WORDS = NUM_IDS / SUM_W,
  localparam int WIDX_W    = $clog2(NUM_WORDS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_IDS*LINES-1:0]   status_flat,
  input  logic [NUM_IDS-1:0]         enable_vec,
  input  logic [NUM_IDS*OWN_W-1:0]   owner_flat,
  input  logic [OWN_W-1:0]           cfg_owner,
  input  logic [OWN_W-1:0]           rd_owner,
  input  logic [WIDX_W-1:0]          rd_word,
  output logic [NUM_IDS-1:0]         mine,
  output logic [SUM_W-1:0]           rd_bits,
  output logic                       irq_out
);

  logic [NUM_IDS-1:0] active;
  logic               cfg_ok;
  logic               rd_ok;

  assign cfg_ok = 32'(cfg_owner) < NUM_OWNERS;
  assign rd_ok  = 32'(rd_owner) < NUM_OWNERS;

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_act
    assign active[g] = enable_vec[g] && (|status_flat[g*LINES +: LINES]);
    assign mine[g]   = active[g] && cfg_ok &&
                       (owner_flat[g*OWN_W +: OWN_W] == cfg_owner);
  end

  always_comb begin
    for (int k = 0; k < SUM_W; k++) begin
      int idx;
      idx = 32'(rd_word) * SUM_W + k;
      rd_bits[k] = active[idx] && rd_ok &&
                   (owner_flat[idx*OWN_W +: OWN_W] == rd_owner);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |mine;
  end

  // R6
  bad_owner_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(cfg_owner) >= NUM_OWNERS) |=> !irq_out);

endmodule

// File: rtl/irqagg_scanner.sv
module irqagg_scanner import irqagg_pkg::*; #(
  parameter int NUM_IDS    = 512,
  parameter int LINES      = 8,
  parameter int SUM_W      = 32,
  localparam int IDX_W     = $clog2(NUM_IDS),
  localparam int LINE_W    = $clog2(LINES),
  localparam int BIT_W     = $clog2(SUM_W),
  localparam int WIDX_W    = IDX_W - BIT_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_IDS-1:0]         mine,
  input  logic [NUM_IDS*LINES-1:0]   status_flat,
  input  logic [IDX_W-1:0]           bnd_min,
  input  logic [IDX_W-1:0]           bnd_max,
  input  logic                       nxt_ready,
  output logic                       nxt_valid,
  output logic [IDX_W-1:0]           nxt_id,
  output logic [LINE_W-1:0]          nxt_line,
  output logic                       ack_en,
  output logic [IDX_W-1:0]           ack_idx,
  output logic [LINES-1:0]           ack_mask
);

  function automatic logic [BIT_W-1:0] low_bit(input logic [SUM_W-1:0] v);
    logic [BIT_W-1:0] r;
    r = '0;
    for (int i = SUM_W - 1; i >= 0; i--) if (v[i]) r = BIT_W'(i);
    return r;
  endfunction

  function automatic logic [LINE_W-1:0] low_line(input logic [LINES-1:0] v);
    logic [LINE_W-1:0] r;
    r = '0;
    for (int i = LINES - 1; i >= 0; i--) if (v[i]) r = LINE_W'(i);
    return r;
  endfunction

  scan_state_e       state_q;
  logic [WIDX_W-1:0] w_q;
  logic [IDX_W-1:0]  cap_q;
  logic [WIDX_W-1:0] first_w;
  logic [WIDX_W-1:0] last_w;
  logic              range_ok;
  logic [SUM_W-1:0]  word_bits;
  logic [LINES-1:0]  cap_lines;

  assign first_w   = bnd_min[IDX_W-1 -: WIDX_W];
  assign last_w    = bnd_max[IDX_W-1 -: WIDX_W];
  assign range_ok  = bnd_min <= bnd_max;
  assign word_bits = mine[32'(w_q)*SUM_W +: SUM_W];
  assign cap_lines = status_flat[32'(cap_q)*LINES +: LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SC_SCAN;
      w_q       <= '0;
      cap_q     <= '0;
      nxt_valid <= 1'b0;
      nxt_id    <= '0;
      nxt_line  <= '0;
    end else begin
      case (state_q)
        SC_SCAN: begin
          if (!range_ok || w_q < first_w || w_q > last_w) begin
            w_q <= first_w;
          end else if (|word_bits) begin
            cap_q   <= {w_q, low_bit(word_bits)};
            state_q <= SC_LINE;
          end else begin
            w_q <= (w_q == last_w) ? first_w : w_q + 1'b1;
          end
        end
        SC_LINE: begin
          if (!mine[cap_q] || cap_lines == '0) begin
            state_q <= SC_SCAN;
            w_q     <= first_w;
          end else begin
            nxt_id    <= cap_q;
            nxt_line  <= low_line(cap_lines);
            nxt_valid <= 1'b1;
            state_q   <= SC_HOLD;
          end
        end
        SC_HOLD: begin
          if (nxt_ready) begin
            nxt_valid <= 1'b0;
            state_q   <= SC_SCAN;
            w_q       <= first_w;
          end
        end
        default: state_q <= SC_SCAN;
      endcase
    end
  end

  assign ack_en   = nxt_valid && nxt_ready;
  assign ack_idx  = nxt_id;
  assign ack_mask = LINES'(1) << nxt_line;

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (nxt_valid && !nxt_ready) |=> (nxt_valid && $stable(nxt_id) && $stable(nxt_line)));

  // R10
  accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (nxt_valid && nxt_ready) |=> !nxt_valid);

  // R9
  range_chk: assert property (@(posedge clk) disable iff (rst)
    nxt_valid |-> (nxt_id[IDX_W-1 -: WIDX_W] >= first_w &&
                   nxt_id[IDX_W-1 -: WIDX_W] <= last_w));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator import irqagg_pkg::*; #(
  parameter int NUM_IDS    = 512,
  parameter int LINES      = 8,
  parameter int NUM_OWNERS = 6,
  parameter int SUM_W      = 32,
  parameter int DATA_W     = 32,
  localparam int IDX_W     = $clog2(NUM_IDS),
  localparam int LINE_W    = $clog2(LINES),
  localparam int OWN_W     = $clog2(NUM_OWNERS),
  localparam int WIDX_W    = $clog2(NUM_IDS / SUM_W),
  localparam int ADDR_W    = IDX_W + 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_IDS*LINES-1:0]  irq_raw,
  input  logic [OWN_W-1:0]          cfg_owner,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  output logic                      irq_out,
  output logic                      nxt_valid,
  output logic [IDX_W-1:0]          nxt_id,
  output logic [LINE_W-1:0]         nxt_line,
  input  logic                      nxt_ready
);

  localparam int MAX_LSB = 16;

  region_e                   region;
  logic [IDX_W-1:0]          idx;
  logic [NUM_IDS*LINES-1:0]  status_flat;
  logic [NUM_IDS-1:0]        enable_vec;
  logic [NUM_IDS*OWN_W-1:0]  owner_flat;
  logic [NUM_IDS-1:0]        mine;
  logic [SUM_W-1:0]          sum_bits;
  logic                      ack_en;
  logic [IDX_W-1:0]          ack_idx;
  logic [LINES-1:0]          ack_mask;
  logic [IDX_W-1:0]          bnd_min_q;
  logic [IDX_W-1:0]          bnd_max_q;
  logic [IDX_W-1:0]          reg_id;
  logic                      cfg_we;
  logic                      clr_we;
  logic                      unused_bits;

  assign region      = region_e'(reg_addr[ADDR_W-1 -: 3]);
  assign idx         = reg_addr[IDX_W-1:0];
  assign reg_id      = reg_wdata[IDX_W-1:0];
  assign cfg_we      = reg_wr && (region == RG_ENABLE || region == RG_OWNER);
  assign clr_we      = reg_wr && (region == RG_CLEAR);
  assign unused_bits = ^{reg_wdata, reg_addr};

  irqagg_id_bank #(
    .NUM_IDS(NUM_IDS), .LINES(LINES), .OWN_W(OWN_W)
  ) u_bank (
    .clk          (clk),
    .rst          (rst),
    .raw          (irq_raw),
    .cfg_we       (cfg_we),
    .cfg_sel_owner(region == RG_OWNER),
    .cfg_idx      (idx),
    .cfg_data     (reg_wdata[OWN_W-1:0]),
    .clr_a_en     (clr_we),
    .clr_a_idx    (idx),
    .clr_a_mask   (reg_wdata[LINES-1:0]),
    .clr_b_en     (ack_en),
    .clr_b_idx    (ack_idx),
    .clr_b_mask   (ack_mask),
    .status_flat  (status_flat),
    .enable_vec   (enable_vec),
    .owner_flat   (owner_flat)
  );

  irqagg_summary #(
    .NUM_IDS(NUM_IDS), .LINES(LINES), .OWN_W(OWN_W),
    .NUM_OWNERS(NUM_OWNERS), .SUM_W(SUM_W)
  ) u_summary (
    .clk        (clk),
    .rst        (rst),
    .status_flat(status_flat),
    .enable_vec (enable_vec),
    .owner_flat (owner_flat),
    .cfg_owner  (cfg_owner),
    .rd_owner   (reg_addr[WIDX_W +: OWN_W]),
    .rd_word    (reg_addr[WIDX_W-1:0]),
    .mine       (mine),
    .rd_bits    (sum_bits),
    .irq_out    (irq_out)
  );

  irqagg_scanner #(
    .NUM_IDS(NUM_IDS), .LINES(LINES), .SUM_W(SUM_W)
  ) u_scan (
    .clk        (clk),
    .rst        (rst),
    .mine       (mine),
    .status_flat(status_flat),
    .bnd_min    (bnd_min_q),
    .bnd_max    (bnd_max_q),
    .nxt_ready  (nxt_ready),
    .nxt_valid  (nxt_valid),
    .nxt_id     (nxt_id),
    .nxt_line   (nxt_line),
    .ack_en     (ack_en),
    .ack_idx    (ack_idx),
    .ack_mask   (ack_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bnd_min_q <= IDX_W'(NUM_IDS - 1);
      bnd_max_q <= '0;
    end else if (reg_wr && region == RG_BOUNDS) begin
      if (reg_id < bnd_min_q) bnd_min_q <= reg_id;
      if (reg_id > bnd_max_q) bnd_max_q <= reg_id;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (region)
        RG_ENABLE:  reg_rdata <= DATA_W'(enable_vec[idx]);
        RG_OWNER:   reg_rdata <= DATA_W'(owner_flat[32'(idx)*OWN_W +: OWN_W]);
        RG_STATUS:  reg_rdata <= DATA_W'(status_flat[32'(idx)*LINES +: LINES]);
        RG_SUMMARY: reg_rdata <= DATA_W'(sum_bits);
        RG_BOUNDS:  reg_rdata <= (DATA_W'(bnd_max_q) << MAX_LSB) | DATA_W'(bnd_min_q);
        default:    reg_rdata <= '0;
      endcase
    end
  end

  // R7
  min_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bnd_min_q <= $past(bnd_min_q)));

  // R7
  max_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bnd_max_q >= $past(bnd_max_q)));

endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;

  localparam int N = 512;
  localparam int L = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N*L-1:0]  irq_raw = '0;
  logic [2:0]      cfg_owner = '0;
  logic            reg_wr = 1'b0;
  logic            reg_rd = 1'b0;
  logic [11:0]     reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            irq_out;
  logic            nxt_valid;
  logic [8:0]      nxt_id;
  logic [2:0]      nxt_line;
  logic            nxt_ready = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst(rst), .irq_raw(irq_raw), .cfg_owner(cfg_owner),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out),
    .nxt_valid(nxt_valid), .nxt_id(nxt_id), .nxt_line(nxt_line),
    .nxt_ready(nxt_ready)
  );

  function automatic logic [11:0] ad(input int region, input int index);
    return 12'((region << 9) | index);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_line(input int id, input int line, input logic v);
    @(negedge clk);
    irq_raw[id*L + line] = v;
    @(negedge clk);
  endtask

  task automatic wait_valid(output int cycles);
    cycles = 0;
    while (!nxt_valid && cycles < 64) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R5 reset irq_out", 32'(irq_out), 32'd0);
    check("R11 reset nxt_valid", 32'(nxt_valid), 32'd0);
    rd(ad(5, 0), d);
    check("R7 reset bounds", d, 32'd511);
    rd(ad(0, 40), d);
    check("R12 reset enable", d, 32'd0);
  endtask

  task automatic t_latch();
    logic [31:0] d;
    set_line(40, 3, 1'b1);
    rd(ad(2, 40), d);
    check("R1 edge latched", d, 32'h08);
    rd(ad(4, 1), d);
    check("R4 disabled id absent from summary", d, 32'h0);
    check("R4 no irq while disabled", 32'(irq_out), 32'd0);
    rd(ad(3, 40), d);
    check("R12 clear region reads zero", d, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(ad(0, 40), 32'h1);
    rd(ad(0, 40), d);
    check("R12 enable readback", d, 32'h1);
    rd(ad(4, 1), d);
    check("R3 summary bit 8 of word 1", d, 32'h100);
    check("R5 irq_out raised", 32'(irq_out), 32'd1);
  endtask

  task automatic t_owner();
    logic [31:0] d;
    wr(ad(1, 40), 32'd2);
    rd(ad(1, 40), d);
    check("R12 owner readback", d, 32'd2);
    rd(ad(4, 1), d);
    check("R6 owner 0 word 1 empty", d, 32'h0);
    rd(ad(4, (2 << 4) | 1), d);
    check("R3 owner 2 word 1", d, 32'h100);
    check("R5 irq_out low for other owner", 32'(irq_out), 32'd0);
    cfg_owner = 3'd2;
    @(negedge clk);
    @(negedge clk);
    check("R5 irq_out follows cfg_owner", 32'(irq_out), 32'd1);
    wr(ad(1, 40), 32'd6);
    rd(ad(4, (6 << 4) | 1), d);
    check("R6 owner 6 summary empty", d, 32'h0);
    cfg_owner = 3'd6;
    @(negedge clk);
    @(negedge clk);
    check("R6 cfg_owner 6 gives no irq", 32'(irq_out), 32'd0);
    wr(ad(1, 40), 32'd0);
    cfg_owner = 3'd0;
    @(negedge clk);
    @(negedge clk);
    check("R5 irq_out restored", 32'(irq_out), 32'd1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(ad(3, 40), 32'h08);
    rd(ad(2, 40), d);
    check("R1 held level does not relatch after clear", d, 32'h0);
    @(negedge clk);
    check("R2 irq_out drops after clear", 32'(irq_out), 32'd0);
    set_line(40, 3, 1'b0);
    @(negedge clk);
    irq_raw[40*L + 3] = 1'b1;
    reg_wr = 1'b1; reg_addr = ad(3, 40); reg_wdata = 32'h08;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(ad(2, 40), d);
    check("R2 same-cycle edge beats clear", d, 32'h08);
    wr(ad(3, 40), 32'hFF);
    rd(ad(2, 40), d);
    check("R2 full clear", d, 32'h0);
  endtask

  task automatic expect_pair(input int id, input int line);
    int cyc;
    wait_valid(cyc);
    check("R8 pair offered", 32'(nxt_valid), 32'd1);
    check("R8 offered id", 32'(nxt_id), 32'(id));
    check("R8 offered line", 32'(nxt_line), 32'(line));
  endtask

  task automatic accept();
    @(negedge clk);
    nxt_ready = 1'b1;
    @(negedge clk);
    nxt_ready = 1'b0;
    check("R10 valid drops after accept", 32'(nxt_valid), 32'd0);
  endtask

  task automatic t_scan();
    logic [31:0] d;
    int ids[5] = '{5, 35, 40, 70, 100};
    foreach (ids[i]) wr(ad(0, ids[i]), 32'h1);
    set_line(70, 6, 1'b1);
    set_line(70, 1, 1'b1);
    set_line(40, 5, 1'b1);
    set_line(100, 0, 1'b1);
    set_line(5, 2, 1'b1);
    set_line(35, 7, 1'b1);
    repeat (20) @(negedge clk);
    check("R9 idle with no registered id", 32'(nxt_valid), 32'd0);
    wr(ad(5, 0), 32'd40);
    expect_pair(35, 7);
    wr(ad(5, 0), 32'd70);
    rd(ad(5, 0), d);
    check("R7 bounds after registration", d, (32'd70 << 16) | 32'd40);
    repeat (3) @(negedge clk);
    check("R11 valid held", 32'(nxt_valid), 32'd1);
    check("R11 id held", 32'(nxt_id), 32'd35);
    check("R11 line held", 32'(nxt_line), 32'd7);
    accept();
    expect_pair(40, 5);
    accept();
    expect_pair(70, 1);
    accept();
    rd(ad(2, 70), d);
    check("R10 only accepted line cleared", d, 32'h40);
    expect_pair(70, 6);
    accept();
    repeat (40) @(negedge clk);
    check("R9 out-of-range words not offered", 32'(nxt_valid), 32'd0);
    rd(ad(2, 100), d);
    check("R9 id 100 still pending", d, 32'h01);
    rd(ad(2, 5), d);
    check("R9 id 5 still pending", d, 32'h04);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latch();
    t_enable();
    t_owner();
    t_clear();
    t_scan();
    finish_run();
  end

endmodule